// File: doc/BRIEF.md
# Video Overlay Layer Window and Control Register Block

This block holds the control state for one video overlay layer and decides, pixel by pixel, whether that layer appears. Software programs it through a simple 32-bit register bus. The bus carries a write strobe, a byte offset and write data, and read data comes back combinationally for the offset on the bus. The registers hold a layer control word, a global alpha, the window rectangle, a status word and three picture-adjust values. The block only stores the picture-adjust values for a later stage to use.

An external display timing generator supplies the current pixel column and line. The block compares them with an inclusive rectangle and registers an in-window flag. It also registers two visibility enables, one for the main mixer and one for the auxiliary mixer. Each enable is gated by its own hide bit in the control word and by the layer's input-enable field. A sticky buffer-underflow flag is set by a pulse from the fetch logic, and software clears it by writing 1 to it.

Top module: `vplane_ctrl`

## Requirements
- R1: After reset the registers read: control 0xC0000007, alpha 0x00000080, window start 0, window end 0, status 0, brightness/contrast 0x00008000, tint 0, saturation 0x00000080.
- R2: Register offsets are control 0x00, alpha 0x04, window start 0x0C, window end 0x10, status 0x68, brightness/contrast 0x70, tint 0x74 and saturation 0x78. A write stores only the implemented bits, and unimplemented bits read as zero. The implemented bits are: control 31:30 and 2:0; alpha 7:0; start and end 27:16 and 11:0; brightness/contrast 15:0; tint 7:0; saturation 7:0.
- R3: A read at any other offset returns zero, and a write to any other offset changes no register.
- R4: The window start holds the first column in bits 11:0 and the first line in bits 27:16. The window end uses the same layout for the last column and last line. A position is inside when start ≤ column ≤ end and start ≤ line ≤ end, with both ends included.
- R5: `in_window` reflects the pixel and line inputs presented before the previous rising clock edge. It is exactly one register stage late.
- R6: `main_vis` is high only when the layer is in the window, control bit 30 is 0, and the input-enable field (control bits 2:0) is nonzero. Control bit 30 = 1 hides the layer from the main mixer only.
- R7: `aux_vis` is high only when the layer is in the window, control bit 31 is 0, and the input-enable field is nonzero. Control bit 31 = 1 hides the layer from the auxiliary mixer only.
- R8: With the input-enable field at zero, both visibility outputs stay low even inside the window, while `in_window` still follows the compare.
- R9: The underflow flag (status bit 0) is set by a one-cycle `underflow_pulse` and stays set. A write of 1 to status bit 0 clears it, and a write of 0 leaves it unchanged.
- R10: When an underflow pulse and a clearing write fall in the same cycle, the flag ends up set.
- R11: A window whose end column is below its start column, or whose end line is below its start line, contains no position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pix_x | input | 12 | Current pixel column from the timing generator |
| pix_y | input | 12 | Current line from the timing generator |
| underflow_pulse | input | 1 | One-cycle buffer underflow event |
| in_window | output | 1 | Registered inclusive window hit |
| main_vis | output | 1 | Registered layer enable for the main mixer |
| aux_vis | output | 1 | Registered layer enable for the auxiliary mixer |

## Verification
On every cycle the assertions check several relations. The in-window flag must match the rectangle compare of the previous cycle's inputs and registers. Each mixer enable must imply the flag, the absence of its hide bit and a nonzero input-enable field. The underflow flag must obey set, clear and set-wins-over-clear.

Other behaviour shows up only in the bench's directed scenarios. These cover the reset values, the exact readback masks at each offset, the silence of undefined offsets, the boundary pixels on every edge of the rectangle, and an inverted rectangle that matches nothing.

// File: rtl/vplane_pkg.sv
package vplane_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int COORD_W = 12;
  localparam int EN_W    = 3;
  localparam int NUM_MIX = 2;

  // Offsets
  localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ALPHA = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_WSTRT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_WEND  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_BCON  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_TINT  = 8'h74;
  localparam logic [ADDR_W-1:0] OFS_SAT   = 8'h78;

  // Field positions
  localparam int HIDE_LSB = 30;
  localparam int ROW_LSB  = 16;

  // Implemented-bit masks
  localparam logic [DATA_W-1:0] MSK_CTL   = 32'hC000_0007;
  localparam logic [DATA_W-1:0] MSK_ALPHA = 32'h0000_00FF;
  localparam logic [DATA_W-1:0] MSK_WIN   = 32'h0FFF_0FFF;
  localparam logic [DATA_W-1:0] MSK_BCON  = 32'h0000_FFFF;
  localparam logic [DATA_W-1:0] MSK_BYTE  = 32'h0000_00FF;

  // Reset values
  localparam logic [DATA_W-1:0] RST_CTL   = 32'hC000_0007;
  localparam logic [DATA_W-1:0] RST_ALPHA = 32'h0000_0080;
  localparam logic [DATA_W-1:0] RST_BCON  = 32'h0000_8000;
  localparam logic [DATA_W-1:0] RST_TINT  = 32'h0000_0000;
  localparam logic [DATA_W-1:0] RST_SAT   = 32'h0000_0080;

  // Inclusive span test on one axis
  function automatic logic span_hit(input logic [COORD_W-1:0] pos,
                                    input logic [COORD_W-1:0] lo,
                                    input logic [COORD_W-1:0] hi);
    return (pos >= lo) && (pos <= hi);
  endfunction

  // Sticky flag next state: set has priority over clear
  function automatic logic sticky_next(input logic cur, input logic set_ev,
                                       input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction
endpackage

// File: rtl/vplane_regfile.sv
module vplane_regfile
  import vplane_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                uf_pulse,
  output logic [NUM_MIX-1:0]  ctl_hide,
  output logic [EN_W-1:0]     ctl_en,
  output logic [COORD_W-1:0]  win_x0,
  output logic [COORD_W-1:0]  win_y0,
  output logic [COORD_W-1:0]  win_x1,
  output logic [COORD_W-1:0]  win_y1,
  output logic                uf_set_ev,
  output logic                uf_clr_ev,
  output logic                uf_flag
);
  logic [DATA_W-1:0] ctl_q, alpha_q, wstrt_q, wend_q, bcon_q, tint_q, sat_q;
  logic              uf_q;

  logic wr_ctl, wr_alpha, wr_wstrt, wr_wend, wr_stat, wr_bcon, wr_tint, wr_sat;

  assign wr_ctl   = bus_we && (bus_addr == OFS_CTL);
  assign wr_alpha = bus_we && (bus_addr == OFS_ALPHA);
  assign wr_wstrt = bus_we && (bus_addr == OFS_WSTRT);
  assign wr_wend  = bus_we && (bus_addr == OFS_WEND);
  assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
  assign wr_bcon  = bus_we && (bus_addr == OFS_BCON);
  assign wr_tint  = bus_we && (bus_addr == OFS_TINT);
  assign wr_sat   = bus_we && (bus_addr == OFS_SAT);

  assign uf_set_ev = uf_pulse;
  assign uf_clr_ev = wr_stat && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= RST_CTL;
      alpha_q <= RST_ALPHA;
      wstrt_q <= '0;
      wend_q  <= '0;
      bcon_q  <= RST_BCON;
      tint_q  <= RST_TINT;
      sat_q   <= RST_SAT;
      uf_q    <= 1'b0;
    end else begin
      if (wr_ctl)   ctl_q   <= bus_wdata & MSK_CTL;
      if (wr_alpha) alpha_q <= bus_wdata & MSK_ALPHA;
      if (wr_wstrt) wstrt_q <= bus_wdata & MSK_WIN;
      if (wr_wend)  wend_q  <= bus_wdata & MSK_WIN;
      if (wr_bcon)  bcon_q  <= bus_wdata & MSK_BCON;
      if (wr_tint)  tint_q  <= bus_wdata & MSK_BYTE;
      if (wr_sat)   sat_q   <= bus_wdata & MSK_BYTE;
      uf_q <= sticky_next(uf_q, uf_set_ev, uf_clr_ev);
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTL:   bus_rdata = ctl_q;
      OFS_ALPHA: bus_rdata = alpha_q;
      OFS_WSTRT: bus_rdata = wstrt_q;
      OFS_WEND:  bus_rdata = wend_q;
      OFS_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, uf_q};
      OFS_BCON:  bus_rdata = bcon_q;
      OFS_TINT:  bus_rdata = tint_q;
      OFS_SAT:   bus_rdata = sat_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign ctl_hide = ctl_q[HIDE_LSB +: NUM_MIX];
  assign ctl_en   = ctl_q[EN_W-1:0];
  assign win_x0   = wstrt_q[COORD_W-1:0];
  assign win_y0   = wstrt_q[ROW_LSB +: COORD_W];
  assign win_x1   = wend_q[COORD_W-1:0];
  assign win_y1   = wend_q[ROW_LSB +: COORD_W];
  assign uf_flag  = uf_q;
endmodule

// File: rtl/vplane_window_gate.sv
module vplane_window_gate
  import vplane_pkg::*;
#(
  parameter int CW = COORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic [CW-1:0] lo_x,
  input  logic [CW-1:0] lo_y,
  input  logic [CW-1:0] hi_x,
  input  logic [CW-1:0] hi_y,
  output logic          hit_d,
  output logic          hit_q
);
  localparam int AXES = 2;

  logic [AXES-1:0][CW-1:0] pos_v, lo_v, hi_v;
  logic [AXES-1:0]         axis_hit;

  assign pos_v = {pos_y, pos_x};
  assign lo_v  = {lo_y, lo_x};
  assign hi_v  = {hi_y, hi_x};

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    assign axis_hit[a] = span_hit(pos_v[a], lo_v[a], hi_v[a]);
  end

  assign hit_d = &axis_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end
endmodule

// File: rtl/vplane_mixer_mask.sv
module vplane_mixer_mask
  import vplane_pkg::*;
#(
  parameter int NMIX = NUM_MIX,
  parameter int EW   = EN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_d,
  input  logic [EW-1:0]   en_field,
  input  logic [NMIX-1:0] hide,
  output logic [NMIX-1:0] vis_q
);
  logic layer_on;
  assign layer_on = |en_field;

  for (genvar m = 0; m < NMIX; m++) begin : g_mix
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vis_q[m] <= 1'b0;
      else        vis_q[m] <= hit_d & layer_on & ~hide[m];
    end
  end
endmodule

// File: rtl/vplane_ctrl.sv
module vplane_ctrl
  import vplane_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [7:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [11:0]  pix_x,
  input  logic [11:0]  pix_y,
  input  logic         underflow_pulse,
  output logic         in_window,
  output logic         main_vis,
  output logic         aux_vis
);
  logic [NUM_MIX-1:0] ctl_hide;
  logic [EN_W-1:0]    ctl_en;
  logic [COORD_W-1:0] win_x0, win_y0, win_x1, win_y1;
  logic               uf_set_ev, uf_clr_ev, uf_flag;
  logic               win_hit_d;
  logic [NUM_MIX-1:0] vis_q;

  vplane_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .uf_pulse  (underflow_pulse),
    .ctl_hide  (ctl_hide),
    .ctl_en    (ctl_en),
    .win_x0    (win_x0),
    .win_y0    (win_y0),
    .win_x1    (win_x1),
    .win_y1    (win_y1),
    .uf_set_ev (uf_set_ev),
    .uf_clr_ev (uf_clr_ev),
    .uf_flag   (uf_flag)
  );

  vplane_window_gate #(.CW(COORD_W)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .pos_x (pix_x),
    .pos_y (pix_y),
    .lo_x  (win_x0),
    .lo_y  (win_y0),
    .hi_x  (win_x1),
    .hi_y  (win_y1),
    .hit_d (win_hit_d),
    .hit_q (in_window)
  );

  vplane_mixer_mask #(.NMIX(NUM_MIX), .EW(EN_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_d    (win_hit_d),
    .en_field (ctl_en),
    .hide     (ctl_hide),
    .vis_q    (vis_q)
  );

  assign main_vis = vis_q[0];
  assign aux_vis  = vis_q[1];
endmodule

// File: rtl/vplane_ctrl_chk.sv
module vplane_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] pix_x,
  input logic [11:0] pix_y,
  input logic        in_window,
  input logic        main_vis,
  input logic        aux_vis,
  input logic [1:0]  ctl_hide,
  input logic [2:0]  ctl_en,
  input logic [11:0] win_x0,
  input logic [11:0] win_y0,
  input logic [11:0] win_x1,
  input logic [11:0] win_y1,
  input logic        uf_set_ev,
  input logic        uf_clr_ev,
  input logic        uf_flag
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R4
  window_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (in_window == $past(pix_x >= win_x0 && pix_x <= win_x1 &&
                                   pix_y >= win_y0 && pix_y <= win_y1)));

  // R6
  main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && main_vis) |-> (in_window && !$past(ctl_hide[0]) && $past(ctl_en) != 3'd0));

  // R7
  aux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && aux_vis) |-> (in_window && !$past(ctl_hide[1]) && $past(ctl_en) != 3'd0));

  // R8
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(ctl_en) == 3'd0) |-> (!main_vis && !aux_vis));

  // R9
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_set_ev |=> uf_flag);

  // R9
  uf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_clr_ev && !uf_set_ev) |=> !uf_flag);

  // R9
  uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf_clr_ev && !uf_set_ev) |=> $stable(uf_flag));

  // R10
  uf_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_clr_ev && uf_set_ev) |=> uf_flag);
endmodule

bind vplane_ctrl vplane_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .in_window (in_window),
  .main_vis  (main_vis),
  .aux_vis   (aux_vis),
  .ctl_hide  (ctl_hide),
  .ctl_en    (ctl_en),
  .win_x0    (win_x0),
  .win_y0    (win_y0),
  .win_x1    (win_x1),
  .win_y1    (win_y1),
  .uf_set_ev (uf_set_ev),
  .uf_clr_ev (uf_clr_ev),
  .uf_flag   (uf_flag)
);

// File: tb/vplane_ctrl_bench.sv
module vplane_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pix_x = '0;
  logic [11:0] pix_y = '0;
  logic        underflow_pulse = 1'b0;
  logic        in_window, main_vis, aux_vis;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  vplane_ctrl u_vplane_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_x(pix_x), .pix_y(pix_y),
    .underflow_pulse(underflow_pulse), .in_window(in_window),
    .main_vis(main_vis), .aux_vis(aux_vis)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // Present a position, let one edge pass, return {aux, main, in_window}
  task automatic probe(input logic [11:0] x, input logic [11:0] y, output logic [2:0] o);
    @(negedge clk);
    pix_x = x; pix_y = y;
    @(negedge clk);
    o = {aux_vis, main_vis, in_window};
  endtask

  function automatic logic ref_in(input int x, input int y, input int x0,
                                  input int y0, input int x1, input int y1);
    return !(x < x0 || x > x1 || y < y0 || y > y1);
  endfunction

  task automatic t_reset_defaults();
    rd_chk("R1 ctl",   8'h00, 32'hC000_0007);
    rd_chk("R1 alpha", 8'h04, 32'h0000_0080);
    rd_chk("R1 start", 8'h0C, 32'h0);
    rd_chk("R1 end",   8'h10, 32'h0);
    rd_chk("R1 stat",  8'h68, 32'h0);
    rd_chk("R1 bcon",  8'h70, 32'h0000_8000);
    rd_chk("R1 tint",  8'h74, 32'h0);
    rd_chk("R1 sat",   8'h78, 32'h0000_0080);
    chk("R1 vis idle", {29'd0, aux_vis, main_vis, 1'b0}, 32'h0);
  endtask

  task automatic t_reg_rw();
    wr(8'h04, 32'hFFFF_FFFF); rd_chk("R2 alpha mask", 8'h04, 32'h0000_00FF);
    wr(8'h0C, 32'hFFFF_FFFF); rd_chk("R2 start mask", 8'h0C, 32'h0FFF_0FFF);
    wr(8'h10, 32'hA5A5_A5A5); rd_chk("R2 end mask",   8'h10, 32'h05A5_05A5);
    wr(8'h70, 32'h1234_5678); rd_chk("R2 bcon mask",  8'h70, 32'h0000_5678);
    wr(8'h74, 32'hFFFF_FF3C); rd_chk("R2 tint mask",  8'h74, 32'h0000_003C);
    wr(8'h78, 32'h0000_01C1); rd_chk("R2 sat mask",   8'h78, 32'h0000_00C1);
    wr(8'h00, 32'hFFFF_FFFF); rd_chk("R2 ctl mask",   8'h00, 32'hC000_0007);
  endtask

  task automatic t_undef();
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h6C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd_chk("R3 read 0x08", 8'h08, 32'h0);
    rd_chk("R3 read 0x6C", 8'h6C, 32'h0);
    rd_chk("R3 read 0x2C", 8'h2C, 32'h0);
    rd_chk("R3 alpha kept", 8'h04, 32'h0000_00FF);
    rd_chk("R3 start kept", 8'h0C, 32'h0FFF_0FFF);
    rd_chk("R3 stat kept",  8'h68, 32'h0);
  endtask

  task automatic t_window();
    logic [2:0] o;
    int xs[8] = '{10, 20,  9, 21, 15, 15, 10, 20};
    int ys[8] = '{ 5,  8,  5,  8,  4,  9,  8,  5};
    wr(8'h00, 32'h0000_0007);
    wr(8'h0C, (32'd5 << 16) | 32'd10);
    wr(8'h10, (32'd8 << 16) | 32'd20);
    for (int i = 0; i < 8; i++) begin
      probe(xs[i][11:0], ys[i][11:0], o);
      chk($sformatf("R4 pos %0d,%0d", xs[i], ys[i]), {31'd0, o[0]},
          {31'd0, ref_in(xs[i], ys[i], 10, 5, 20, 8)});
    end
    // latency: outside then inside, flag must not move before the edge
    probe(12'd0, 12'd0, o);
    @(negedge clk);
    pix_x = 12'd12; pix_y = 12'd6;
    #1 chk("R5 before edge", {31'd0, in_window}, 32'd0);
    @(posedge clk); #1
    chk("R5 after edge", {31'd0, in_window}, 32'd1);
  endtask

  task automatic t_mixer_mask();
    logic [2:0] o;
    wr(8'h00, 32'h0000_0007); probe(12'd15, 12'd6, o);
    chk("R6 R7 both shown", {29'd0, o}, 32'd7);
    wr(8'h00, 32'h4000_0007); probe(12'd15, 12'd6, o);
    chk("R6 main hidden", {29'd0, o}, 32'd5);
    wr(8'h00, 32'h8000_0001); probe(12'd15, 12'd6, o);
    chk("R7 aux hidden", {29'd0, o}, 32'd3);
    wr(8'h00, 32'h0000_0004); probe(12'd30, 12'd6, o);
    chk("R6 R7 outside", {29'd0, o}, 32'd0);
    wr(8'h00, 32'h0000_0000); probe(12'd15, 12'd6, o);
    chk("R8 enable off", {29'd0, o}, 32'd1);
    wr(8'h00, 32'h0000_0007);
    wr(8'h0C, (32'd5 << 16) | 32'd30);
    probe(12'd25, 12'd6, o);
    chk("R11 inverted cols", {29'd0, o}, 32'd0);
    wr(8'h0C, (32'd9 << 16) | 32'd10);
    probe(12'd15, 12'd8, o);
    chk("R11 inverted rows", {29'd0, o}, 32'd0);
  endtask

  task automatic t_underflow();
    @(negedge clk); underflow_pulse = 1'b1;
    @(negedge clk); underflow_pulse = 1'b0;
    rd_chk("R9 set", 8'h68, 32'd1);
    repeat (3) @(negedge clk);
    rd_chk("R9 sticky", 8'h68, 32'd1);
    wr(8'h68, 32'hFFFF_FFFE); rd_chk("R9 write0 no clear", 8'h68, 32'd1);
    wr(8'h68, 32'd1);         rd_chk("R9 write1 clears", 8'h68, 32'd0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h68; bus_wdata = 32'd1; underflow_pulse = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; underflow_pulse = 1'b0;
    rd_chk("R10 set wins", 8'h68, 32'd1);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_defaults();
    t_reg_rw();
    t_undef();
    t_window();
    t_mixer_mask();
    t_underflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule